// File: doc/BRIEF.md
# Four-Mode Barrel Shift Unit

This block is the shift datapath of a 32-bit processor execute stage. It is purely combinational. It receives the current instruction word and two register operand values: the value to be shifted and a count register. It returns the 32-bit result that is written back to the destination register. Four opcodes are served: logical right, arithmetic right, logical left and left rotate.

The shift distance comes from one of two places. It is taken from a 5-bit count field at the bottom of the instruction when that field is nonzero. When the field is zero, the five low bits of the count register supply the distance instead. Any other opcode produces a zero result with the valid flag low, so the surrounding execute logic can merge this result with the other units.

Top module: `shu_top`

## Requirements
- R1: When instruction bits [4:0] are nonzero, they are the shift count.
- R2: When instruction bits [4:0] are zero, the count is `cnt_reg[4:0]`. Bits [31:5] of `cnt_reg` never affect the result.
- R3: Opcode 26 (instruction bits [31:27]) gives a logical right shift. Zeros enter from the top.
- R4: Opcode 27 gives an arithmetic right shift. Copies of `src[31]` enter from the top, so 0x97EAEC16 shifted by 13 gives 0xFFFCBF57.
- R5: Opcode 28 gives a logical left shift. Zeros enter from the bottom.
- R6: Opcode 29 rotates left. The top n bits reappear at the bottom, and the number of set bits is unchanged.
- R7: A resolved count of 0 returns `src` unchanged in all four modes.
- R8: Any opcode other than 26 to 29 drives `result` to zero and `valid` low.
- R9: `valid` is high for opcodes 26 to 29.
- R10: Instruction bits [26:5] have no effect on `result` or `valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word: opcode in [31:27], count field in [4:0] |
| src | input | 32 | Value to be shifted |
| cnt_reg | input | 32 | Count register; only [4:0] is used |
| result | output | 32 | Shifted value, or zero for a non-shift opcode |
| valid | output | 1 | High when the opcode is one of the four shifts |

## Verification
The in-RTL checks assume that all three inputs hold known, settled values whenever they are evaluated. They also assume that a new instruction is presented whole, rather than one field at a time while other fields are in motion. The bench changes every input in a single step between clock edges and compares only after that step has settled. The stimulus sets the filler bits of the instruction and the upper bits of the count register to random values. Because of this, those checks see the cases where unused bits are nonzero.

// File: rtl/shu_pkg.sv
package shu_pkg;

  typedef enum logic [1:0] {
    SHM_RIGHT_LOG = 2'd0,
    SHM_RIGHT_ARI = 2'd1,
    SHM_LEFT_LOG  = 2'd2,
    SHM_ROT_LEFT  = 2'd3
  } shu_mode_e;

  localparam int unsigned OPC_W = 5;
  localparam logic [OPC_W-1:0] OPC_SHR  = 5'd26;
  localparam logic [OPC_W-1:0] OPC_SHRA = 5'd27;
  localparam logic [OPC_W-1:0] OPC_SHL  = 5'd28;
  localparam logic [OPC_W-1:0] OPC_ROTL = 5'd29;

endpackage

// File: rtl/shu_decode.sv
module shu_decode
  import shu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output shu_mode_e        mode,
  output logic             is_shift
);

  always_comb begin
    mode     = SHM_RIGHT_LOG;
    is_shift = 1'b1;
    unique case (opcode)
      OPC_SHR:  mode = SHM_RIGHT_LOG;
      OPC_SHRA: mode = SHM_RIGHT_ARI;
      OPC_SHL:  mode = SHM_LEFT_LOG;
      OPC_ROTL: mode = SHM_ROT_LEFT;
      default:  is_shift = 1'b0;
    endcase
  end

  // R9 / R8: valid exactly for the four shift opcodes
  always_comb begin
    p_shift_window_r9: assert ((opcode >= OPC_SHR && opcode <= OPC_ROTL) == is_shift)
      else $error("decode window mismatch");
  end

endmodule

// File: rtl/shu_count_sel.sv
module shu_count_sel #(
  parameter int unsigned CW = 5
) (
  input  logic [CW-1:0] field_cnt,
  input  logic [CW-1:0] reg_cnt,
  output logic [CW-1:0] count,
  output logic          from_reg
);

  function automatic logic [CW-1:0] pick_count(input logic [CW-1:0] f,
                                               input logic [CW-1:0] r);
    return (f != '0) ? f : r;
  endfunction

  assign from_reg = (field_cnt == '0);
  assign count    = pick_count(field_cnt, reg_cnt);

  always_comb begin
    // R1: a nonzero field is used as is
    p_field_wins_r1: assert (from_reg || count == field_cnt)
      else $error("field count not used");
    // R2: a zero field defers to the register
    p_reg_fallback_r2: assert (!from_reg || count == reg_cnt)
      else $error("register count not used");
  end

endmodule

// File: rtl/shu_barrel.sv
module shu_barrel
  import shu_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amt,
  input  shu_mode_e     mode,
  output logic [W-1:0]  dout
);

  function automatic logic [W-1:0] step(input logic [W-1:0] d,
                                        input int unsigned k,
                                        input shu_mode_e m);
    logic [2*W-1:0] wide;
    logic [W-1:0]   r;
    unique case (m)
      SHM_RIGHT_LOG: r = d >> k;
      SHM_RIGHT_ARI: begin
        wide = {{W{d[W-1]}}, d} >> k;
        r    = wide[W-1:0];
      end
      SHM_LEFT_LOG:  r = d << k;
      default:       r = (d << k) | (d >> (W - k));
    endcase
    return r;
  endfunction

  logic [W-1:0] stage_q [CW+1];

  assign stage_q[0] = din;

  for (genvar s = 0; s < CW; s++) begin : g_stage
    logic [W-1:0] moved;
    assign moved        = step(stage_q[s], 1 << s, mode);
    assign stage_q[s+1] = amt[s] ? moved : stage_q[s];

    // R6: every rotate stage keeps the set-bit population
    always_comb begin
      p_rot_stage_pop_r6: assert (mode != SHM_ROT_LEFT ||
                                  $countones(stage_q[s+1]) == $countones(stage_q[s]))
        else $error("rotate stage lost bits");
    end
  end

  assign dout = stage_q[CW];

endmodule

// File: rtl/shu_top.sv
module shu_top
  import shu_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0] instr,
  input  logic [W-1:0] src,
  input  logic [W-1:0] cnt_reg,
  output logic [W-1:0] result,
  output logic         valid
);

  localparam int unsigned OPC_LSB = W - OPC_W;

  shu_mode_e     mode;
  logic          is_shift;
  logic [CW-1:0] count;
  logic          from_reg;
  logic [W-1:0]  shifted;
  logic          zero_count;

  shu_decode u_decode (
    .opcode   (instr[W-1:OPC_LSB]),
    .mode     (mode),
    .is_shift (is_shift)
  );

  shu_count_sel #(.CW(CW)) u_count (
    .field_cnt (instr[CW-1:0]),
    .reg_cnt   (cnt_reg[CW-1:0]),
    .count     (count),
    .from_reg  (from_reg)
  );

  shu_barrel #(.W(W), .CW(CW)) u_barrel (
    .din  (src),
    .amt  (count),
    .mode (mode),
    .dout (shifted)
  );

  assign zero_count = (count == '0);
  assign valid      = is_shift;
  assign result     = is_shift ? shifted : '0;

  always_comb begin
    // R7: zero count is a pass-through
    p_zero_pass_r7: assert (!(valid && zero_count) || result == src)
      else $error("zero count altered operand");
    // R8: non-shift opcodes give zero
    p_idle_zero_r8: assert (valid || result == '0)
      else $error("non-shift result not zero");
    // R3: logical right with a nonzero count clears the top bit
    p_shr_top_r3: assert (!(valid && mode == SHM_RIGHT_LOG && !zero_count) || !result[W-1])
      else $error("logical right top bit set");
    // R4: arithmetic right keeps the sign
    p_shra_sign_r4: assert (!(valid && mode == SHM_RIGHT_ARI) || result[W-1] == src[W-1])
      else $error("arithmetic right lost sign");
    // R5: left shift with a nonzero count clears bit 0
    p_shl_low_r5: assert (!(valid && mode == SHM_LEFT_LOG && !zero_count) || !result[0])
      else $error("left shift bit 0 set");
    // R6: rotate keeps the set-bit population end to end
    p_rot_pop_r6: assert (!(valid && mode == SHM_ROT_LEFT) ||
                          $countones(result) == $countones(src))
      else $error("rotate population changed");
  end

endmodule

// File: tb/shu_top_tb.sv
module shu_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src = '0;
  logic [31:0] cnt_reg = '0;
  logic [31:0] result;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shu_top u_dut (
    .instr   (instr),
    .src     (src),
    .cnt_reg (cnt_reg),
    .result  (result),
    .valid   (valid)
  );

  function automatic logic [31:0] model(input int op, input logic [31:0] x, input int n);
    case (op)
      26: return x >> n;
      27: return 32'($signed(x) >>> n);
      28: return x << n;
      29: return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] exp_r, input logic exp_v);
    checks++;
    if (result !== exp_r || valid !== exp_v) begin
      errors++;
      $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
               tag, result, valid, exp_r, exp_v);
    end
  endtask

  // Drive at the falling edge, compare one quarter period later.
  task automatic apply(input int op, input logic [21:0] filler, input logic [4:0] fld,
                       input logic [31:0] x, input logic [31:0] c);
    @(negedge clk);
    instr   = {op[4:0], filler, fld};
    src     = x;
    cnt_reg = c;
    #5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset/idle state: all inputs zero, opcode 0 (R8)
    apply(0, '0, '0, '0, '0);
    check("R8 idle", 32'd0, 1'b0);

    // R4 worked example, count from field
    apply(27, '0, 5'd13, 32'h97EAEC16, '0);
    check("R4 example field", 32'hFFFCBF57, 1'b1);
    // R2: same via register, high bits junk
    apply(27, '0, 5'd0, 32'h97EAEC16, 32'hABCDE00D);
    check("R2 example register", 32'hFFFCBF57, 1'b1);
    // R1: field wins over register
    apply(28, '0, 5'd4, 32'h0000_00F1, 32'h0000_0007);
    check("R1 field wins", 32'h0000_0F10, 1'b1);

    // R3 R4 R5 R6 R1 R2 R7 R10: sweep all modes and counts, both sources
    for (int op = 26; op <= 29; op++) begin
      for (int n = 0; n < 32; n++) begin
        for (int k = 0; k < 3; k++) begin
          logic [31:0] x;
          logic [21:0] fill;
          logic [31:0] junk;
          x    = (k == 0) ? 32'h8000_0001 : $urandom;
          fill = 22'($urandom);
          junk = $urandom;
          // count from field (R1); register holds junk, filler random (R10)
          apply(op, fill, n[4:0], x, junk);
          if (n == 0) begin
            // field zero: count is junk[4:0] (R2)
            check($sformatf("R2 op%0d via reg", op), model(op, x, int'(junk[4:0])), 1'b1);
          end else begin
            check($sformatf("R1 op%0d n%0d field", op, n), model(op, x, n), 1'b1);
          end
          // count from register (R2), upper register bits random
          apply(op, fill, 5'd0, x, {junk[31:5], n[4:0]});
          check($sformatf("R3-6 op%0d n%0d reg", op, n), model(op, x, n), 1'b1);
          if (n == 0) begin
            // R7: resolved count zero passes through
            check($sformatf("R7 op%0d pass", op), x, 1'b1);
          end
        end
      end
    end

    // R8 / R9: non-shift opcodes, including neighbours 25 and 30
    for (int op = 0; op < 32; op++) begin
      apply(op, 22'($urandom), 5'd3, 32'hDEAD_BEEF, 32'h1);
      if (op >= 26 && op <= 29)
        check($sformatf("R9 op%0d valid", op), model(op, 32'hDEAD_BEEF, 3), 1'b1);
      else
        check($sformatf("R8 op%0d idle", op), 32'd0, 1'b0);
    end

    // R10: filler bits all ones vs all zeros give identical results
    apply(29, 22'h3FFFFF, 5'd8, 32'h1234_5678, '0);
    check("R10 filler ones", 32'h3456_7812, 1'b1);
    apply(29, 22'h0, 5'd8, 32'h1234_5678, '0);
    check("R10 filler zeros", 32'h3456_7812, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule